// File: doc/BRIEF.md
# Multichannel ADC Smoothing Filter

This block sits behind a shared analog-to-digital converter that cycles through six cell-voltage channels. Every conversion result arrives with the index of the channel it belongs to. For each channel the block keeps its own first-order recursive low-pass estimate. The sample is doubled before it is blended with the old estimate, so the settled output is twice the raw code and carries one extra bit of resolution. The estimate is held with four fractional bits, and only the integer part is presented.

A controller reads any channel on demand. It asserts a read request with a channel index, and one cycle later it receives the integer part of that channel's estimate together with a valid strobe. Nothing is streamed out. The serial link is noisy while it transmits, so its busy flag stops every sample from reaching the filter state during that time.

After reset, the first accepted sample for a channel loads that channel's estimate directly with twice the sample. The filter therefore does not have to ramp up from zero.

Top module: `cell_adc_smoother`

## Requirements
- R1: After synchronous reset every channel reads back 0, and `rd_valid` is low until a read is requested.
- R2: The first accepted sample for a channel after reset sets that channel's estimate to exactly 2×`smp_code`, so a read returns 2×`smp_code`.
- R3: Every later accepted sample updates the 15-bit estimate S (11 integer bits, 4 fractional bits) to floor((32×code + 15×S)/16), and a read returns floor(S/16).
- R4: A sample is accepted in a cycle only when `smp_valid` is 1, `tx_busy` is 0 and `smp_chan` is below 6. Only the addressed channel changes.
- R5: While `tx_busy` is 1, no channel's estimate changes, whatever is present on the sample inputs.
- R6: A sample with a channel index of 6 or 7 changes no channel.
- R7: A read request in one cycle makes `rd_valid` 1 in the next cycle, with `rd_value` equal to the integer part of the addressed channel's estimate before that edge. `rd_valid` is 0 after any cycle without a request. A read of index 6 or 7 returns 0.
- R8: The output never exceeds 2046. When a channel is primed with 1023 and keeps receiving 1023, it reads exactly 2046 every time.
- R9: The channels are independent: updating one channel leaves the other five unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A conversion result is present |
| smp_chan | input | 3 | Channel index of the result |
| smp_code | input | 10 | Raw conversion code |
| tx_busy | input | 1 | Serial link is transmitting; blocks all updates |
| rd_req | input | 1 | Read request |
| rd_chan | input | 3 | Channel to read |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_value | output | 11 | Integer part of the filtered estimate |

## Verification
The priming path is hard to reach from the ports, because it runs only once per channel per reset. The bench therefore resets the block before every one of the 1024 possible codes, sends each code as a first sample and reads it back. The truncation behaviour of the recursion only appears after long runs with mixed codes. A bench-side pseudo-random stream interleaves samples, busy periods, out-of-range indices and reads on every cycle for thousands of cycles, and compares each read against an integer model.

// File: rtl/adc_smooth_pkg.sv
package adc_smooth_pkg;
    localparam int NUM_CH   = 6;
    localparam int SAMPLE_W = 10;
    localparam int FRAC_W   = 4;
    localparam int SHIFT_C  = 4;

    typedef struct packed {
        logic                valid;
        logic [2:0]          chan;
        logic [SAMPLE_W-1:0] code;
    } smp_t;
endpackage

// File: rtl/adc_smooth_update.sv
module adc_smooth_update #(
    parameter int SAMPLE_W = adc_smooth_pkg::SAMPLE_W,
    parameter int FRAC_W   = adc_smooth_pkg::FRAC_W,
    parameter int SHIFT_C  = adc_smooth_pkg::SHIFT_C,
    localparam int ACC_W   = SAMPLE_W + 1 + FRAC_W
) (
    input  logic [ACC_W-1:0]    old_state,
    input  logic [SAMPLE_W-1:0] code,
    input  logic                primed,
    output logic [ACC_W-1:0]    new_state
);
    localparam int BLEND_W = ACC_W + SHIFT_C + 1;

    logic [BLEND_W-1:0] doubled_fx;
    logic [BLEND_W-1:0] blend;

    always_comb begin
        // twice the sample, aligned to the fractional point
        doubled_fx = BLEND_W'({code, 1'b0}) << FRAC_W;
        blend      = doubled_fx + (BLEND_W'(old_state) << SHIFT_C) - BLEND_W'(old_state);
        if (primed) begin
            new_state = ACC_W'(blend >> SHIFT_C);
        end else begin
            new_state = ACC_W'(doubled_fx);
        end
    end
endmodule

// File: rtl/adc_smooth_bank.sv
module adc_smooth_bank #(
    parameter int NUM_CH   = adc_smooth_pkg::NUM_CH,
    parameter int SAMPLE_W = adc_smooth_pkg::SAMPLE_W,
    parameter int FRAC_W   = adc_smooth_pkg::FRAC_W,
    parameter int SHIFT_C  = adc_smooth_pkg::SHIFT_C,
    localparam int ACC_W   = SAMPLE_W + 1 + FRAC_W,
    localparam int CH_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept,
    input  logic [CH_W-1:0]              sel,
    input  logic [SAMPLE_W-1:0]          code,
    input  logic                         hold,
    output logic [NUM_CH-1:0][ACC_W-1:0] state_o
);
    localparam logic [ACC_W-1:0] STATE_MAX = ACC_W'(((1 << (SAMPLE_W + 1)) - 2) << FRAC_W);

    logic [NUM_CH-1:0][ACC_W-1:0] state_q;
    logic [NUM_CH-1:0]            primed_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic             wr_en;
        logic [ACC_W-1:0] nxt;

        assign wr_en = accept && (sel == CH_W'(g));

        adc_smooth_update #(
            .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .SHIFT_C(SHIFT_C)
        ) upd_i (
            .old_state(state_q[g]),
            .code     (code),
            .primed   (primed_q[g]),
            .new_state(nxt)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[g]  <= '0;
                primed_q[g] <= 1'b0;
            end else if (wr_en) begin
                state_q[g]  <= nxt;
                primed_q[g] <= 1'b1;
            end
        end

        AST_UNPRIMED_ZERO: assert property (@(posedge clk) disable iff (rst)
            !primed_q[g] |-> state_q[g] == '0);                               // R1
        AST_PRIME_STICKS: assert property (@(posedge clk) disable iff (rst)
            primed_q[g] |=> primed_q[g]);                                     // R2
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            state_q[g] <= STATE_MAX);                                         // R8
    end

    assign state_o = state_q;

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(state_q));                                           // R5
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(primed_q ^ $past(primed_q)) <= 1);                // R9
endmodule

// File: rtl/cell_adc_smoother.sv
module cell_adc_smoother #(
    parameter int NUM_CH   = adc_smooth_pkg::NUM_CH,
    parameter int SAMPLE_W = adc_smooth_pkg::SAMPLE_W,
    parameter int FRAC_W   = adc_smooth_pkg::FRAC_W,
    parameter int SHIFT_C  = adc_smooth_pkg::SHIFT_C,
    localparam int ACC_W   = SAMPLE_W + 1 + FRAC_W,
    localparam int OUT_W   = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [2:0]          smp_chan,
    input  logic [SAMPLE_W-1:0] smp_code,
    input  logic                tx_busy,
    input  logic                rd_req,
    input  logic [2:0]          rd_chan,
    output logic                rd_valid,
    output logic [OUT_W-1:0]    rd_value
);
    import adc_smooth_pkg::*;

    smp_t                         smp;
    logic                         chan_ok;
    logic                         accept;
    logic [NUM_CH-1:0][ACC_W-1:0] states;
    logic [OUT_W-1:0]             rd_mux;

    assign smp     = '{valid: smp_valid, chan: smp_chan, code: smp_code};
    assign chan_ok = (32'(smp.chan) < NUM_CH);
    assign accept  = smp.valid && !tx_busy && chan_ok;

    adc_smooth_bank #(
        .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .SHIFT_C(SHIFT_C)
    ) bank_i (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .sel    (smp.chan),
        .code   (smp.code),
        .hold   (tx_busy),
        .state_o(states)
    );

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_chan == 3'(c)) rd_mux = OUT_W'(states[c] >> FRAC_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_value <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_value <= rd_mux;
        end
    end

    AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);                                                 // R7
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);                                               // R7
    AST_BAD_INDEX_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_req && 32'(rd_chan) >= NUM_CH) |=> rd_value == '0);               // R7
    AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && 32'(smp_chan) >= NUM_CH) |=> $stable(states));          // R6
    AST_VALUE_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_value <= OUT_W'((1 << OUT_W) - 2));                   // R8
endmodule

// File: tb/cell_adc_smoother_tb.sv
module cell_adc_smoother_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_chan = '0;
    logic [9:0]  smp_code = '0;
    logic        tx_busy = 1'b0;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_chan = '0;
    logic        rd_valid;
    logic [10:0] rd_value;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    int  model [6];
    bit  primed [6];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    cell_adc_smoother dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_code(smp_code), .tx_busy(tx_busy), .rd_req(rd_req),
        .rd_chan(rd_chan), .rd_valid(rd_valid), .rd_value(rd_value)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got cycle %0d, expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 0; rd_req = 0; tx_busy = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 6; c++) begin model[c] = 0; primed[c] = 0; end
    endtask

    // One cycle: drive at negedge, update model at posedge, check after it.
    task automatic step(input bit v, input int ch, input int code, input bit busy,
                        input bit rq, input int rch, input string tag);
        int exp_val;
        @(negedge clk);
        smp_valid = v; smp_chan = 3'(ch); smp_code = 10'(code);
        tx_busy = busy; rd_req = rq; rd_chan = 3'(rch);
        @(posedge clk);
        exp_val = (rch < 6) ? model[rch] / 16 : 0;
        if (v && !busy && ch < 6) begin
            if (!primed[ch]) model[ch] = 32 * code;
            else             model[ch] = (32 * code + 15 * model[ch]) / 16;
            primed[ch] = 1;
        end
        #1;
        check({tag, " valid"}, int'(rd_valid), int'(rq));
        if (rq) check(tag, int'(rd_value), exp_val);
    endtask

    initial begin
        int pre [6];
        do_reset();
        // R1: reset state
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        for (int c = 0; c < 6; c++) step(0, 0, 0, 0, 1, c, "R1 reset read");

        // R2: exhaustive priming sweep
        for (int code = 0; code < 1024; code++) begin
            do_reset();
            step(1, code % 6, code, 0, 0, 0, "R2 prime");
            step(0, 0, 0, 0, 1, code % 6, "R2 first sample doubled");
        end

        // R8: max input held constant stays at 2046
        do_reset();
        for (int k = 0; k < 40; k++) step(1, 5, 1023, 0, 1, 5, "R8 saturate hold");
        check("R8 final value", int'(rd_value), 2046);
        for (int k = 0; k < 10; k++) step(1, 5, 0, 0, 1, 5, "R3 max to zero");

        // R5: busy freezes, R6: bad index ignored, R9 independence
        do_reset();
        for (int c = 0; c < 6; c++) step(1, c, 100 * (c + 1), 0, 0, 0, "R4 fill");
        for (int c = 0; c < 6; c++) pre[c] = model[c] / 16;
        for (int k = 0; k < 12; k++) step(1, k % 6, 1000, 1, 0, 0, "R5 busy stimulus");
        for (int c = 0; c < 6; c++) step(0, 0, 0, 0, 1, c, "R5 busy frozen");
        for (int k = 0; k < 8; k++) step(1, 6 + (k % 2), 999, 0, 0, 0, "R6 bad index");
        for (int c = 0; c < 6; c++) step(0, 0, 0, 0, 1, c, "R6 unchanged");
        for (int k = 0; k < 5; k++) step(1, 2, 7, 0, 0, 0, "R9 update one");
        for (int c = 0; c < 6; c++) begin
            step(0, 0, 0, 0, 1, c, "R9 others intact");
            if (c != 2) check("R9 vs pre-busy", int'(rd_value), pre[c]);
        end
        step(0, 0, 0, 0, 1, 7, "R7 bad index read");

        // R3/R4/R7 mixed pseudo-random stream
        do_reset();
        for (int k = 0; k < 6000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], int'(lfsr[4:2]) % 8, int'(lfsr[15:6]),
                 (lfsr[7:5] == 3'd0), lfsr[8] | lfsr[9], int'(lfsr[12:10]) % 7,
                 "R3 stream");
        end
        step(0, 0, 0, 0, 0, 0, "R7 idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule